// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI shifter from the module clock. A single clock-control register selects one of two division laws. Under the linear law the serial clock runs at the module clock divided by 2·(n+1), with n taken from an 8-bit field. Under the exponential law it runs at the module clock divided by 2^(n+1), with n taken from a 4-bit field. With a 24 MHz module clock the linear law reaches down to about 47 kHz. The exponential law covers the slow end down to a few hundred hertz, below the roughly 3 kHz that the clock-control setting procedure needs.

The divider runs only while `run` is high, meaning an exchange is in progress. While `run` is low the serial clock rests at the idle polarity given on `cpol`, and the half-period counter is held cleared. While running, the block flips `sclk` once every half-period and raises `sclk_tgl` for the one module-clock cycle in which the new level first appears. The shifter uses that pulse as its toggle-enable.

A write to the clock-control register lands in a shadow copy. The divider adopts a new setting only when a half-period ends, or at once while idle. The serial clock therefore never produces a shortened pulse. The duty cycle is 50% under both laws.

Top module: `spi_clkdiv`

## Requirements
- R1: While reset is asserted, `sclk` and `sclk_tgl` are 0. The clock-control register resets to all zeros, which selects the exponential law with n=0, so the half-period is 1 module clock.
- R2: At each rising edge that samples `run` low, `sclk` takes the value of `cpol` sampled at that edge and `sclk_tgl` goes to 0.
- R3: With bit 12 of the clock-control register set (linear law), the half-period is H = n2+1 module clocks, where n2 is bits 7:0. `sclk` first changes on the H-th rising edge that samples `run` high, and changes again every H edges after that.
- R4: With bit 12 clear (exponential law), the half-period is H = 2^n1 module clocks, where n1 is bits 11:8. The edge timing is the same as in R3.
- R5: A rising edge with `ctl_wr` high loads `ctl_wdata[12:0]` into the register. The field that the selected law does not use has no effect on the period.
- R6: `sclk_tgl` is 1 in exactly those cycles whose `sclk` value differs from the previous cycle's while running. It is 0 in every other cycle.
- R7: A register write made during a half-period does not change the length of that half-period. The new setting applies from the next half-period.
- R8: While `run` is high, `cpol` has no effect on `sclk`.
- R9: The extreme settings work: linear n2=0 and exponential n1=0 give H=1 (module clock divided by 2), linear n2=255 gives H=256, and exponential n1=15 gives H=32768.
- R10: Dropping `run` part-way through a half-period returns `sclk` to `cpol` one edge later. When `run` rises again, counting restarts from zero, so the next change comes after a full H edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Write strobe for the clock-control register |
| ctl_wdata | input | 13 | Write data: [7:0] linear n2, [11:8] exponential n1, [12] linear-law select |
| run | input | 1 | High while an exchange is in progress |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| sclk_tgl | output | 1 | One-cycle strobe marking each serial clock change |

## Verification
Every result is registered once, so a change in `run`, `cpol` or the register shows at the outputs on the first rising edge that samples it. The exception is a register write made while idle: it reaches the active setting one edge later, so the bench leaves one idle cycle after each write before raising `run`. The bench drives inputs on falling edges, counts rising edges from the one that first samples `run` high, and reads `sclk` and `sclk_tgl` on the falling edge after each rising edge. The serial clock is due to change on the H-th counted edge. For a mid-period write, the bench counts the edges spent on the write into the same total, so the half-period in progress must still end at the old H.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    localparam int unsigned DEF_LIN_W = 8;
    localparam int unsigned DEF_EXP_W = 4;

    // Counter width able to hold the largest half-period minus one under either law.
    function automatic int unsigned cnt_width(int unsigned lin_w, int unsigned exp_w);
        int unsigned e;
        e = (1 << exp_w) - 1;
        return (lin_w > e) ? lin_w : e;
    endfunction

endpackage

// File: rtl/spi_clkdiv_ctlreg.sv
module spi_clkdiv_ctlreg #(
    parameter int unsigned LIN_W = spi_clkdiv_pkg::DEF_LIN_W,
    parameter int unsigned EXP_W = spi_clkdiv_pkg::DEF_EXP_W,
    localparam int unsigned CTL_W = LIN_W + EXP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic             lin_sel,
    output logic [LIN_W-1:0] lin_div,
    output logic [EXP_W-1:0] exp_div
);

    // Field order mirrors the register layout: select on top, linear field at the bottom.
    typedef struct packed {
        logic             sel;
        logic [EXP_W-1:0] ediv;
        logic [LIN_W-1:0] ldiv;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = ctl_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign lin_sel = ctl_q.sel;
    assign lin_div = ctl_q.ldiv;
    assign exp_div = ctl_q.ediv;

endmodule

// File: rtl/spi_clkdiv_limit.sv
module spi_clkdiv_limit #(
    parameter int unsigned LIN_W = spi_clkdiv_pkg::DEF_LIN_W,
    parameter int unsigned EXP_W = spi_clkdiv_pkg::DEF_EXP_W,
    localparam int unsigned CNT_W = spi_clkdiv_pkg::cnt_width(LIN_W, EXP_W)
) (
    input  logic             lin_sel,
    input  logic [LIN_W-1:0] lin_div,
    input  logic [EXP_W-1:0] exp_div,
    output logic [CNT_W-1:0] half_lim
);

    logic [CNT_W-1:0] exp_lim;
    logic [CNT_W-1:0] lin_lim;

    // Exponential law: half-period 2^n, so the terminal count is a mask of n low ones.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign exp_lim[i] = (i < int'(exp_div));
    end

    // Linear law: half-period n+1, so the terminal count is n itself.
    assign lin_lim = CNT_W'(lin_div);

    always_comb begin
        half_lim = lin_sel ? lin_lim : exp_lim;
    end

endmodule

// File: rtl/spi_clkdiv_engine.sv
module spi_clkdiv_engine #(
    parameter int unsigned LIN_W = spi_clkdiv_pkg::DEF_LIN_W,
    parameter int unsigned EXP_W = spi_clkdiv_pkg::DEF_EXP_W,
    localparam int unsigned CNT_W = spi_clkdiv_pkg::cnt_width(LIN_W, EXP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cpol,
    input  logic             shd_sel,
    input  logic [LIN_W-1:0] shd_lin,
    input  logic [EXP_W-1:0] shd_exp,
    input  logic [CNT_W-1:0] half_lim,
    output logic             act_sel,
    output logic [LIN_W-1:0] act_lin,
    output logic [EXP_W-1:0] act_exp,
    output logic             sclk,
    output logic             sclk_tgl
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic             tgl;
        logic             sel;
        logic [LIN_W-1:0] lin;
        logic [EXP_W-1:0] expn;
    } eng_t;

    eng_t st_d, st_q;
    logic at_edge;

    assign at_edge = (st_q.cnt == half_lim);

    always_comb begin
        st_d     = st_q;
        st_d.tgl = 1'b0;
        if (!run) begin
            // Idle: park at the polarity and track the shadow setting.
            st_d.cnt  = '0;
            st_d.sclk = cpol;
            st_d.sel  = shd_sel;
            st_d.lin  = shd_lin;
            st_d.expn = shd_exp;
        end else if (at_edge) begin
            // Half-period boundary: flip, and only here adopt a new setting.
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
            st_d.tgl  = 1'b1;
            st_d.sel  = shd_sel;
            st_d.lin  = shd_lin;
            st_d.expn = shd_exp;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_sel  = st_q.sel;
    assign act_lin  = st_q.lin;
    assign act_exp  = st_q.expn;
    assign sclk     = st_q.sclk;
    assign sclk_tgl = st_q.tgl;

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int unsigned LIN_W = spi_clkdiv_pkg::DEF_LIN_W,
    parameter int unsigned EXP_W = spi_clkdiv_pkg::DEF_EXP_W,
    localparam int unsigned CTL_W = LIN_W + EXP_W + 1,
    localparam int unsigned CNT_W = spi_clkdiv_pkg::cnt_width(LIN_W, EXP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             run,
    input  logic             cpol,
    output logic             sclk,
    output logic             sclk_tgl
);

    logic             shd_sel;
    logic [LIN_W-1:0] shd_lin;
    logic [EXP_W-1:0] shd_exp;
    logic             act_sel;
    logic [LIN_W-1:0] act_lin;
    logic [EXP_W-1:0] act_exp;
    logic [CNT_W-1:0] half_lim;

    spi_clkdiv_ctlreg #(.LIN_W(LIN_W), .EXP_W(EXP_W)) ctlreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .wr_data (ctl_wdata),
        .lin_sel (shd_sel),
        .lin_div (shd_lin),
        .exp_div (shd_exp)
    );

    spi_clkdiv_limit #(.LIN_W(LIN_W), .EXP_W(EXP_W)) limit_i (
        .lin_sel  (act_sel),
        .lin_div  (act_lin),
        .exp_div  (act_exp),
        .half_lim (half_lim)
    );

    spi_clkdiv_engine #(.LIN_W(LIN_W), .EXP_W(EXP_W)) engine_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cpol     (cpol),
        .shd_sel  (shd_sel),
        .shd_lin  (shd_lin),
        .shd_exp  (shd_exp),
        .half_lim (half_lim),
        .act_sel  (act_sel),
        .act_lin  (act_lin),
        .act_exp  (act_exp),
        .sclk     (sclk),
        .sclk_tgl (sclk_tgl)
    );

endmodule

// File: rtl/spi_clkdiv_chk.sv
module spi_clkdiv_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic cpol,
    input logic sclk,
    input logic sclk_tgl
);

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sclk == $past(cpol)));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk_tgl);

    // R6
    tgl_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_tgl |-> (sclk != $past(sclk)));

    // R6
    change_has_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && (sclk != $past(sclk))) |-> sclk_tgl);

endmodule

bind spi_clkdiv spi_clkdiv_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cpol     (cpol),
    .sclk     (sclk),
    .sclk_tgl (sclk_tgl)
);

// File: tb/spi_clkdiv_tb_top.sv
module spi_clkdiv_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [12:0] ctl_wdata = '0;
    logic        run = 1'b0;
    logic        cpol = 1'b0;
    logic        sclk;
    logic        sclk_tgl;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_clkdiv dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .run       (run),
        .cpol      (cpol),
        .sclk      (sclk),
        .sclk_tgl  (sclk_tgl)
    );

    // Vector: [31] unused-field flag, [30] cpol, [29:17] register value, [16:0] expected half-period
    localparam logic [31:0] VEC [8] = '{
        {1'b0, 1'b0, 13'h1000, 17'd1},
        {1'b0, 1'b1, 13'h1003, 17'd4},
        {1'b0, 1'b0, 13'h10FF, 17'd256},
        {1'b1, 1'b1, 13'h1705, 17'd6},
        {1'b0, 1'b0, 13'h0000, 17'd1},
        {1'b1, 1'b1, 13'h03AA, 17'd8},
        {1'b0, 1'b0, 13'h0600, 17'd64},
        {1'b0, 1'b1, 13'h0F00, 17'd32768}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [12:0] v);
        @(negedge clk);
        ctl_wdata = v;
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
        @(negedge clk);
    endtask

    // Counts rising edges until sclk changes; also verifies the toggle strobe on every cycle.
    task automatic wait_toggle(output int n, output bit tg_ok);
        logic start;
        start = sclk;
        n = 0;
        tg_ok = 1'b1;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (sclk !== start) begin
                if (sclk_tgl !== 1'b1) tg_ok = 1'b0;
            end else if (sclk_tgl !== 1'b0) begin
                tg_ok = 1'b0;
            end
        end while (sclk === start && n < 40000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        bit tok;
        string tag;

        // R1: reset values
        repeat (3) @(negedge clk);
        check(sclk === 1'b0, "R1 sclk in reset", int'(sclk), 0);
        check(sclk_tgl === 1'b0, "R1 tgl in reset", int'(sclk_tgl), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1: reset register means exponential n1=0, half-period 1
        run = 1'b1;
        wait_toggle(n, tok);
        check(n == 1, "R1 reset setting half-period", n, 1);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);

        // Table walk: R3, R4, R5, R9, R6, R10
        for (int v = 0; v < 8; v++) begin
            logic [12:0] cv;
            int h;
            cv = VEC[v][29:17];
            h = int'(VEC[v][16:0]);
            if (VEC[v][31]) tag = "R5";
            else if (h == 1 || h == 256 || h == 32768) tag = "R9";
            else if (cv[12]) tag = "R3";
            else tag = "R4";
            cpol = VEC[v][30];
            run = 1'b0;
            wr_ctl(cv);
            check(sclk === cpol, "R2 idle level", int'(sclk), int'(cpol));
            run = 1'b1;
            wait_toggle(n, tok);
            check(n == h, {tag, " first half-period"}, n, h);
            check(sclk === ~cpol, {tag, " level after first change"}, int'(sclk), int'(~cpol));
            check(tok, "R6 strobe on first half", int'(tok), 1);
            wait_toggle(n, tok);
            check(n == h, {tag, " second half-period"}, n, h);
            check(tok, "R6 strobe on second half", int'(tok), 1);
            run = 1'b0;
            @(negedge clk);
            check(sclk === cpol, "R10 return to idle", int'(sclk), int'(cpol));
            check(sclk_tgl === 1'b0, "R2 no strobe when idle", int'(sclk_tgl), 0);
        end

        // R2: cpol change while idle
        cpol = 1'b1;
        @(negedge clk);
        check(sclk === 1'b1, "R2 idle follows cpol high", int'(sclk), 1);
        cpol = 1'b0;
        @(negedge clk);
        check(sclk === 1'b0, "R2 idle follows cpol low", int'(sclk), 0);

        // R7: mid-period write keeps the running half-period
        wr_ctl(13'h1009);
        run = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ctl_wdata = 13'h1001;
        ctl_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0;
        wait_toggle(n, tok);
        check(n == 6, "R7 old half-period completes", n + 4, 10);
        wait_toggle(n, tok);
        check(n == 2, "R7 new half-period applies", n, 2);
        run = 1'b0;
        @(negedge clk);

        // R8: cpol ignored while running
        cpol = 1'b0;
        wr_ctl(13'h1003);
        run = 1'b1;
        wait_toggle(n, tok);
        check(n == 4, "R8 first half", n, 4);
        cpol = 1'b1;
        wait_toggle(n, tok);
        check(n == 4, "R8 half unchanged by cpol", n, 4);
        check(sclk === 1'b0, "R8 level unchanged by cpol", int'(sclk), 0);
        run = 1'b0;
        @(negedge clk);
        check(sclk === 1'b1, "R2 idle after run with cpol high", int'(sclk), 1);

        // R10: stop mid-period then restart from zero
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check(sclk === 1'b1, "R10 idle level after abort", int'(sclk), 1);
        check(sclk_tgl === 1'b0, "R10 no strobe after abort", int'(sclk_tgl), 0);
        run = 1'b1;
        wait_toggle(n, tok);
        check(n == 4, "R10 full half-period after restart", n, 4);
        run = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule